// File: doc/BRIEF.md
# PHY Link Bring-Up Sequencer

This block takes an external Ethernet PHY from power-up to a negotiated link by driving a management-register command port. A separate management master performs each read or write on the serial bus. On a start request the sequencer can first reset the PHY and wait for the reset to finish. It then clears the isolate bit in the control register. Next it reads the PHY's ability bits, builds an advertisement trimmed to the configured speed and duplex limits, starts negotiation and polls for completion. A remote fault seen during the wait restarts negotiation.

Polling is paced by an external `tick` strobe, so each poll waits for one tick. Both wait loops are bounded. When the reset wait runs out, the run aborts. When the negotiation wait runs out, the timeout flag is raised and the run still finishes. In fixed mode the block skips negotiation and writes the requested speed and duplex straight into the control register. The resolved speed and duplex are presented together with `done` and stay unchanged until the next start.

Top module: `phy_linkup_seq`

## Requirements
- R1: After reset, `busy`, `done`, `cmd_valid`, `timeout`, `reset_fail`, `remote_fault`, `link_speed100` and `link_full_duplex` are all 0.
- R2: Once `cmd_valid` is raised, it stays high with `cmd_write`, `cmd_reg` and `cmd_wdata` unchanged until the cycle in which `cmd_done` is seen. Each command is issued exactly once.
- R3: When `cfg_phy_reset` is set at start, the block first writes 0x8000 to register 0. After each `tick` it reads register 0, until bit 15 reads as 0. If 50 reads all show bit 15 set, `reset_fail` and `done` rise and no further command is issued.
- R4: Before negotiation or fixed setup, register 0 is read and written back with bit 10 cleared and every other bit unchanged.
- R5: The advertisement written to register 4 always has bit 0 set. Status register 1 ability bits 15, 14, 13, 12 and 11 (T4, 100 full, 100 half, 10 full, 10 half) map to advertisement bits 9, 8, 7, 6 and 5. An ability bit is advertised only when the status register reports that ability.
- R6: With `cfg_speed100` low, advertisement bits 9, 8 and 7 are cleared. With `cfg_full_duplex` low, bits 8 and 6 are cleared.
- R7: Negotiation starts with a write of 0x1200 to register 0. After each `tick`, register 1 is read, and negotiation is complete when bit 5 is set.
- R8: A poll that returns bit 5 clear and bit 4 set, and is not the last poll, is followed by another write of 0x1200 to register 0. `remote_fault` equals bit 4 of the final status read.
- R9: After 50 status polls with bit 5 clear, `timeout` is set and the sequence continues to the result read.
- R10: After negotiation, register 18 is read. Bit 7 gives `link_speed100` and bit 6 gives `link_full_duplex`. These outputs and `done` hold until the next start.
- R11: With `cfg_aneg_en` low, the block writes register 0 with bit 13 = `cfg_speed100`, bit 8 = `cfg_full_duplex` and all other bits 0. It does not advertise or poll, and it reports the configured speed and duplex.
- R12: A `start` pulse while `busy` is high has no effect on the command sequence or on the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a bring-up run (honoured only when idle) |
| tick | input | 1 | Poll-interval strobe |
| cfg_phy_reset | input | 1 | Reset the PHY first |
| cfg_aneg_en | input | 1 | 1: negotiate, 0: fixed mode |
| cfg_speed100 | input | 1 | Allow / force 100 Mb/s |
| cfg_full_duplex | input | 1 | Allow / force full duplex |
| cmd_valid | output | 1 | Management command request |
| cmd_write | output | 1 | 1 = write, 0 = read |
| cmd_reg | output | 5 | PHY register number |
| cmd_wdata | output | 16 | Write data |
| cmd_done | input | 1 | Command complete strobe |
| cmd_rdata | input | 16 | Read data, valid with `cmd_done` |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, results valid |
| timeout | output | 1 | Negotiation poll limit reached |
| reset_fail | output | 1 | PHY reset never released |
| remote_fault | output | 1 | Fault bit of the last status poll |
| link_speed100 | output | 1 | Resolved speed is 100 Mb/s |
| link_full_duplex | output | 1 | Resolved duplex is full |

## Verification
The internal state of this block is visible only as its sequence of management commands. The bench therefore compares every command against an expected stream, at the moment it is issued. If a wrong state is taken, or the poll count is off by one, the very next command differs in register, direction or data. That shows up within one command latency, and not only once `done` appears. A wrong advertisement or a wrong read-modify-write value shows up as wrong write data on that same command. A poll counter that is off by one shows up as one extra or one missing status read before `timeout` or `reset_fail`.

// File: rtl/phy_linkup_pkg.sv
package phy_linkup_pkg;
  localparam int REG_W = 5;
  localparam int DAT_W = 16;

  localparam logic [REG_W-1:0] RA_CTRL = 5'd0;
  localparam logic [REG_W-1:0] RA_STAT = 5'd1;
  localparam logic [REG_W-1:0] RA_ADV  = 5'd4;
  localparam logic [REG_W-1:0] RA_OUT  = 5'd18;

  // control register bits
  localparam int CB_RESET   = 15;
  localparam int CB_SPEED   = 13;
  localparam int CB_ANEN    = 12;
  localparam int CB_ISO     = 10;
  localparam int CB_RESTART = 9;
  localparam int CB_DPLX    = 8;
  // status register bits
  localparam int SB_T4   = 15;
  localparam int SB_TXF  = 14;
  localparam int SB_TXH  = 13;
  localparam int SB_10F  = 12;
  localparam int SB_10H  = 11;
  localparam int SB_DONE = 5;
  localparam int SB_RFLT = 4;
  // advertisement bits
  localparam int AB_SEL = 0;
  localparam int AB_T4  = 9;
  localparam int AB_TXF = 8;
  localparam int AB_TXH = 7;
  localparam int AB_10F = 6;
  localparam int AB_10H = 5;
  // status-output register bits
  localparam int OB_SPD = 7;
  localparam int OB_DPX = 6;

  typedef enum logic [3:0] {
    S_IDLE, S_RST_WR, S_RST_WAIT, S_RST_RD, S_CTL_RD, S_CTL_WR,
    S_CAP_RD, S_ADV_WR, S_AN_WR, S_AN_WAIT, S_AN_RD, S_OUT_RD, S_FIX_WR
  } seq_state_t;
endpackage

// File: rtl/phy_linkup_adv.sv
module phy_linkup_adv
  import phy_linkup_pkg::*;
(
  input  logic [DAT_W-1:0] stat,
  input  logic             allow_100,
  input  logic             allow_full,
  output logic [DAT_W-1:0] adv
);
  always_comb begin
    adv          = '0;
    adv[AB_SEL]  = 1'b1;
    adv[AB_T4]   = stat[SB_T4]  & allow_100;
    adv[AB_TXF]  = stat[SB_TXF] & allow_100 & allow_full;
    adv[AB_TXH]  = stat[SB_TXH] & allow_100;
    adv[AB_10F]  = stat[SB_10F] & allow_full;
    adv[AB_10H]  = stat[SB_10H];
  end
endmodule

// File: rtl/phy_linkup_poll_ctr.sv
module phy_linkup_poll_ctr #(
  parameter int MAX = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int CW = $clog2(MAX + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  assign last = (cnt == CW'(MAX - 1));
endmodule

// File: rtl/phy_linkup_seq.sv
module phy_linkup_seq
  import phy_linkup_pkg::*;
#(
  parameter int POLL_MAX = 50
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             tick,
  input  logic             cfg_phy_reset,
  input  logic             cfg_aneg_en,
  input  logic             cfg_speed100,
  input  logic             cfg_full_duplex,
  output logic             cmd_valid,
  output logic             cmd_write,
  output logic [REG_W-1:0] cmd_reg,
  output logic [DAT_W-1:0] cmd_wdata,
  input  logic             cmd_done,
  input  logic [DAT_W-1:0] cmd_rdata,
  output logic             busy,
  output logic             done,
  output logic             timeout,
  output logic             reset_fail,
  output logic             remote_fault,
  output logic             link_speed100,
  output logic             link_full_duplex
);
  localparam logic [DAT_W-1:0] RST_WORD = DAT_W'(1) << CB_RESET;
  localparam logic [DAT_W-1:0] AN_WORD  = (DAT_W'(1) << CB_ANEN) | (DAT_W'(1) << CB_RESTART);
  localparam logic [DAT_W-1:0] ISO_MASK = ~(DAT_W'(1) << CB_ISO);

  seq_state_t       state;
  logic             an_q, s100_q, fd_q;
  logic [DAT_W-1:0] adv_word, fix_word;
  logic             poll_clr, poll_inc, poll_last;

  phy_linkup_adv u_adv (
    .stat(cmd_rdata), .allow_100(s100_q), .allow_full(fd_q), .adv(adv_word)
  );

  always_comb begin
    fix_word           = '0;
    fix_word[CB_SPEED] = s100_q;
    fix_word[CB_DPLX]  = fd_q;
    poll_clr = (state == S_IDLE) || (state == S_ADV_WR);
    poll_inc = cmd_done && (((state == S_RST_RD) && cmd_rdata[CB_RESET]) ||
                            ((state == S_AN_RD) && !cmd_rdata[SB_DONE]));
  end

  phy_linkup_poll_ctr #(.MAX(POLL_MAX)) u_poll (
    .clk(clk), .rst(rst), .clr(poll_clr), .inc(poll_inc), .last(poll_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      cmd_valid <= 1'b0; cmd_write <= 1'b0; cmd_reg <= '0; cmd_wdata <= '0;
      busy <= 1'b0; done <= 1'b0; timeout <= 1'b0; reset_fail <= 1'b0;
      remote_fault <= 1'b0; link_speed100 <= 1'b0; link_full_duplex <= 1'b0;
      an_q <= 1'b0; s100_q <= 1'b0; fd_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          busy <= 1'b1; done <= 1'b0; timeout <= 1'b0; reset_fail <= 1'b0;
          remote_fault <= 1'b0; link_speed100 <= 1'b0; link_full_duplex <= 1'b0;
          an_q <= cfg_aneg_en; s100_q <= cfg_speed100; fd_q <= cfg_full_duplex;
          cmd_valid <= 1'b1; cmd_reg <= RA_CTRL;
          if (cfg_phy_reset) begin
            cmd_write <= 1'b1; cmd_wdata <= RST_WORD; state <= S_RST_WR;
          end else begin
            cmd_write <= 1'b0; cmd_wdata <= '0; state <= S_CTL_RD;
          end
        end
        S_RST_WR: if (cmd_done) begin
          cmd_valid <= 1'b0; state <= S_RST_WAIT;
        end
        S_RST_WAIT: if (tick) begin
          cmd_valid <= 1'b1; cmd_write <= 1'b0; cmd_reg <= RA_CTRL; cmd_wdata <= '0;
          state <= S_RST_RD;
        end
        S_RST_RD: if (cmd_done) begin
          if (!cmd_rdata[CB_RESET]) begin
            cmd_write <= 1'b0; cmd_reg <= RA_CTRL; cmd_wdata <= '0; state <= S_CTL_RD;
          end else if (poll_last) begin
            reset_fail <= 1'b1; busy <= 1'b0; done <= 1'b1; cmd_valid <= 1'b0;
            state <= S_IDLE;
          end else begin
            cmd_valid <= 1'b0; state <= S_RST_WAIT;
          end
        end
        S_CTL_RD: if (cmd_done) begin
          cmd_write <= 1'b1; cmd_reg <= RA_CTRL; cmd_wdata <= cmd_rdata & ISO_MASK;
          state <= S_CTL_WR;
        end
        S_CTL_WR: if (cmd_done) begin
          if (an_q) begin
            cmd_write <= 1'b0; cmd_reg <= RA_STAT; cmd_wdata <= '0; state <= S_CAP_RD;
          end else begin
            cmd_write <= 1'b1; cmd_reg <= RA_CTRL; cmd_wdata <= fix_word; state <= S_FIX_WR;
          end
        end
        S_CAP_RD: if (cmd_done) begin
          cmd_write <= 1'b1; cmd_reg <= RA_ADV; cmd_wdata <= adv_word; state <= S_ADV_WR;
        end
        S_ADV_WR: if (cmd_done) begin
          cmd_write <= 1'b1; cmd_reg <= RA_CTRL; cmd_wdata <= AN_WORD; state <= S_AN_WR;
        end
        S_AN_WR: if (cmd_done) begin
          cmd_valid <= 1'b0; state <= S_AN_WAIT;
        end
        S_AN_WAIT: if (tick) begin
          cmd_valid <= 1'b1; cmd_write <= 1'b0; cmd_reg <= RA_STAT; cmd_wdata <= '0;
          state <= S_AN_RD;
        end
        S_AN_RD: if (cmd_done) begin
          remote_fault <= cmd_rdata[SB_RFLT];
          if (cmd_rdata[SB_DONE] || poll_last) begin
            timeout <= !cmd_rdata[SB_DONE];
            cmd_write <= 1'b0; cmd_reg <= RA_OUT; cmd_wdata <= '0; state <= S_OUT_RD;
          end else if (cmd_rdata[SB_RFLT]) begin
            cmd_write <= 1'b1; cmd_reg <= RA_CTRL; cmd_wdata <= AN_WORD; state <= S_AN_WR;
          end else begin
            cmd_valid <= 1'b0; state <= S_AN_WAIT;
          end
        end
        S_OUT_RD: if (cmd_done) begin
          link_speed100 <= cmd_rdata[OB_SPD]; link_full_duplex <= cmd_rdata[OB_DPX];
          busy <= 1'b0; done <= 1'b1; cmd_valid <= 1'b0; state <= S_IDLE;
        end
        S_FIX_WR: if (cmd_done) begin
          link_speed100 <= s100_q; link_full_duplex <= fd_q;
          busy <= 1'b0; done <= 1'b1; cmd_valid <= 1'b0; state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/phy_linkup_seq_chk.sv
module phy_linkup_seq_chk
  import phy_linkup_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             cmd_valid,
  input logic             cmd_write,
  input logic [REG_W-1:0] cmd_reg,
  input logic [DAT_W-1:0] cmd_wdata,
  input logic             cmd_done,
  input logic             busy,
  input logic             done,
  input logic             reset_fail,
  input logic             link_speed100,
  input logic             link_full_duplex
);
  // R2: request held steady until the master completes it
  assert_cmd_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_done) |=> (cmd_valid && $stable(cmd_write) &&
                                  $stable(cmd_reg) && $stable(cmd_wdata)));

  // R1: no command traffic outside a run
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !cmd_valid);

  // R10: results and done are never shown during a run
  assert_busy_done_R10: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  // R10: results hold until the next start
  assert_result_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(link_speed100) && $stable(link_full_duplex)));

  // R3: a reset failure ends the run
  assert_rst_fail_end_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(reset_fail) |-> (done && !busy && !cmd_valid));
endmodule

bind phy_linkup_seq phy_linkup_seq_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
  .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata), .cmd_done(cmd_done), .busy(busy),
  .done(done), .reset_fail(reset_fail), .link_speed100(link_speed100),
  .link_full_duplex(link_full_duplex)
);

// File: tb/phy_linkup_seq_test.sv
`timescale 1ns/1ps
module phy_linkup_seq_test;
  logic clk = 1'b0, rst = 1'b1, start = 1'b0, tick = 1'b0;
  logic cfg_phy_reset = 0, cfg_aneg_en = 0, cfg_speed100 = 0, cfg_full_duplex = 0;
  logic cmd_valid, cmd_write, cmd_done = 1'b0;
  logic [4:0] cmd_reg;
  logic [15:0] cmd_wdata, cmd_rdata = '0;
  logic busy, done, timeout, reset_fail, remote_fault, link_speed100, link_full_duplex;

  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  phy_linkup_seq uut (
    .clk(clk), .rst(rst), .start(start), .tick(tick),
    .cfg_phy_reset(cfg_phy_reset), .cfg_aneg_en(cfg_aneg_en),
    .cfg_speed100(cfg_speed100), .cfg_full_duplex(cfg_full_duplex),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_reg(cmd_reg),
    .cmd_wdata(cmd_wdata), .cmd_done(cmd_done), .cmd_rdata(cmd_rdata),
    .busy(busy), .done(done), .timeout(timeout), .reset_fail(reset_fail),
    .remote_fault(remote_fault), .link_speed100(link_speed100),
    .link_full_duplex(link_full_duplex)
  );

  int tcnt = 0;
  always @(posedge clk) begin
    tcnt <= (tcnt == 7) ? 0 : tcnt + 1;
    tick <= (tcnt == 7);
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard queue of expected commands
  typedef struct { bit w; bit [4:0] r; bit [15:0] d; string req; } exp_t;
  exp_t q[$];

  task automatic push(bit w, bit [4:0] r, bit [15:0] d, string req);
    exp_t e; e.w = w; e.r = r; e.d = d; e.req = req; q.push_back(e);
  endtask

  // PHY model state
  int m_rst_left = 0, m_k = 0, m_aa = 1, m_fl = 0, m_fh = -1;
  bit [15:0] m_ctrl = '0, m_caps = '0, m_out = '0;

  // monitor: pops expected commands and answers as the PHY
  initial begin
    forever begin
      @(negedge clk);
      if (cmd_valid) begin
        exp_t e;
        bit [15:0] rd;
        if (q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R12: actual=unexpected command reg %0d expected=none", cmd_reg);
          e.w = cmd_write; e.r = cmd_reg; e.d = cmd_wdata; e.req = "R12";
        end else begin
          e = q.pop_front();
          chk({e.req, " dir"}, {31'd0, cmd_write}, {31'd0, e.w});
          chk({e.req, " reg"}, {27'd0, cmd_reg}, {27'd0, e.r});
          if (e.w) chk({e.req, " data"}, {16'd0, cmd_wdata}, {16'd0, e.d});
        end
        rd = '0;
        if (!cmd_write) begin
          if (cmd_reg == 5'd0) begin
            rd = m_ctrl;
            if (m_rst_left > 0) begin rd[15] = 1'b1; m_rst_left--; end
          end else if (cmd_reg == 5'd1) begin
            rd = m_caps;
            if (m_k >= m_aa) rd[5] = 1'b1;
            if (m_k >= m_fl && m_k <= m_fh) rd[4] = 1'b1;
            m_k++;
          end else if (cmd_reg == 5'd18) rd = m_out;
        end
        repeat (2) @(negedge clk);
        cmd_rdata = rd; cmd_done = 1'b1;
        @(negedge clk);
        cmd_done = 1'b0; cmd_rdata = '0;
      end
    end
  end

  task automatic run(string tag, bit rs, int rl, bit an, bit s100, bit fd,
                     bit [15:0] cb, bit [15:0] cp, int aa, int fl, int fh,
                     bit [15:0] o18, bit poke);
    bit e_rf = 0, e_to = 0, e_flt = 0, e_s = 0, e_d = 0;
    bit stop = 0;
    bit [15:0] adv;
    q.delete();
    m_rst_left = rs ? rl : 0; m_k = 0; m_aa = aa; m_fl = fl; m_fh = fh;
    m_ctrl = cb; m_caps = cp; m_out = o18;
    if (rs) begin
      push(1, 0, 16'h8000, "R3");
      for (int i = 1; i <= 50; i++) begin
        push(0, 0, 0, "R3");
        if (i > rl) break;
        if (i == 50) begin e_rf = 1; stop = 1; end
      end
    end
    if (!stop) begin
      push(0, 0, 0, "R4");
      push(1, 0, cb & 16'hFBFF, "R4");
      if (!an) begin
        push(1, 0, (s100 ? 16'h2000 : 16'h0) | (fd ? 16'h0100 : 16'h0), "R11");
        e_s = s100; e_d = fd;
      end else begin
        push(0, 1, 0, "R5");
        adv = 16'h0001;
        if (cp[15] && s100)       adv |= 16'h0200;
        if (cp[14] && s100 && fd) adv |= 16'h0100;
        if (cp[13] && s100)       adv |= 16'h0080;
        if (cp[12] && fd)         adv |= 16'h0040;
        if (cp[11])               adv |= 16'h0020;
        push(1, 4, adv, "R6");
        push(1, 0, 16'h1200, "R7");
        for (int i = 1; i <= 50; i++) begin
          bit dn, f;
          push(0, 1, 0, "R7");
          dn = (i >= aa); f = (i >= fl && i <= fh);
          e_flt = f;
          if (dn) break;
          if (i == 50) begin e_to = 1; break; end
          if (f) push(1, 0, 16'h1200, "R8");
        end
        push(0, 18, 0, "R10");
        e_s = o18[7]; e_d = o18[6];
      end
    end
    @(negedge clk);
    cfg_phy_reset = rs; cfg_aneg_en = an; cfg_speed100 = s100; cfg_full_duplex = fd;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cfg_phy_reset = 0; cfg_aneg_en = ~an; cfg_speed100 = ~s100; cfg_full_duplex = ~fd;
    if (poke) begin
      repeat (20) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    repeat (6) @(negedge clk);
    chk({tag, " R2 queue drained"}, q.size(), 0);
    chk({tag, " R10 done"}, {30'd0, done, busy}, 32'd2);
    chk({tag, " R3 reset_fail"}, {31'd0, reset_fail}, {31'd0, e_rf});
    chk({tag, " R9 timeout"}, {31'd0, timeout}, {31'd0, e_to});
    chk({tag, " R8 remote_fault"}, {31'd0, remote_fault}, {31'd0, e_flt});
    chk({tag, " R10 speed"}, {31'd0, link_speed100}, {31'd0, e_s});
    chk({tag, " R10 duplex"}, {31'd0, link_full_duplex}, {31'd0, e_d});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset outputs",
        {25'd0, busy, done, cmd_valid, timeout, reset_fail, remote_fault, link_speed100},
        32'd0);
    chk("R1 reset duplex", {31'd0, link_full_duplex}, 32'd0);
    // full abilities, 100 full, quick completion
    run("a", 0, 0, 1, 1, 1, 16'h3400, 16'hF800, 3, 0, -1, 16'h00C0, 0);
    // PHY reset released after two busy reads, 10 Mb/s only
    run("b", 1, 2, 1, 0, 1, 16'h0400, 16'hF800, 2, 0, -1, 16'h0040, 0);
    // 100 half, remote fault on two polls, stray start mid-run (R12)
    run("c", 0, 0, 1, 1, 0, 16'h1000, 16'h6800, 4, 1, 2, 16'h0080, 1);
    // never completes, fault on final polls (R9)
    run("d", 0, 0, 1, 1, 1, 16'h0000, 16'h7800, 1000, 49, 99, 16'h0000, 0);
    // reset never released (R3)
    run("e", 1, 100, 1, 1, 1, 16'h0000, 16'hF800, 1, 0, -1, 16'h00C0, 0);
    // fixed mode (R11)
    run("f", 0, 0, 0, 1, 1, 16'h1500, 16'h0000, 1, 0, -1, 16'h0000, 0);
    run("g", 1, 0, 0, 0, 0, 16'h0400, 16'h0000, 1, 0, -1, 16'h0000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule